// File: doc/BRIEF.md
# I2C Slave Read Responder

This block sits on an I2C bus as a target that serves read requests from a bus master. It synchronises the SCL and SDA lines into the system clock domain, detects START and STOP conditions, and collects the first byte after each START. When the seven address bits match the programmed own address and the direction bit requests a read, the block acknowledges and then shifts out bytes fetched from a transmit buffer over a valid/ready handshake. SDA is driven open-drain: the block only ever pulls the line low.

Three events set sticky status bits: the byte that closes a buffer has been sent, the master did not acknowledge a byte, or a transmit error happened (no data at address time, or the buffer ran empty mid-read). Each bit is cleared by writing 1 and is gated by its own mask bit into a single registered interrupt line. When the buffer runs dry after a master ACK, the block keeps SDA released, so the master reads all-ones until it issues STOP.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, sda_oe is 0, tx_ready is 0, irq_status is 0 and irq is 0.
- R2: The first byte after a START is taken MSB first; bits 7..1 are compared with own_addr and bit 0 must be 1 (read). On a match with tx_valid high the block pulls SDA low during the ninth clock (ACK).
- R3: After the ACK clock, each popped byte is sent MSB first, one bit per SCL low phase; tx_ready pulses for exactly one clock per byte taken, and tx_data is taken in that clock.
- R4: On an address match with tx_valid low, the address is not acknowledged, nothing is popped and status bit 2 (error) is set.
- R5: On an address mismatch or a write request, the address is not acknowledged, nothing is popped and SDA stays released until the next START.
- R6: If the master does not acknowledge a data byte, the block releases SDA, stops sending and sets status bit 1 (abort).
- R7: When all eight bits of a byte taken with tx_last high have been sent, status bit 0 (done) is set.
- R8: If the master acknowledges a byte and tx_valid is low, status bit 2 is set and SDA stays released (all-ones) until STOP or START.
- R9: A START in the middle of a transfer (repeated START) discards partial bits and restarts address reception.
- R10: Writing 1 to an irq_clr bit clears that status bit. irq is one clock behind the OR of irq_status AND irq_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line as seen on the pad |
| sda_in | input | 1 | SDA line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| own_addr | input | 7 | Programmed 7-bit slave address |
| tx_data | input | 8 | Next byte to transmit |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_last | input | 1 | tx_data is the final byte of the buffer |
| tx_ready | output | 1 | One-clock pop strobe for tx_data |
| irq_mask | input | 3 | Per-source enable: bit0 done, bit1 abort, bit2 error |
| irq_clr | input | 3 | Write-1-to-clear strobe, same bit order |
| irq_status | output | 3 | Sticky event bits, same bit order |
| irq | output | 1 | Masked combined interrupt |

## Verification
The bench chases the address decision: an address one bit off, a write request, and a correct address with an empty buffer. A design that compared the wrong bits or ignored tx_valid would acknowledge and pop data. Underrun is driven by reading past the buffer; a design that stalled or replayed stale data would return something other than 0xFF or miss the error bit. Random reads vary the buffer length against the bytes the master reads, which separates the done, abort and error outcomes. A repeated START after a few address bits exposes a design that keeps stale shift bits.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_MACK, ST_FILL
  } stx_state_e;

  localparam int IRQ_N     = 3;
  localparam int IRQ_DONE  = 0;
  localparam int IRQ_ABORT = 1;
  localparam int IRQ_ERR   = 2;
endpackage

// File: rtl/i2c_stx_sync.sv
module i2c_stx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_stx_cond.sv
module i2c_stx_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign bus_start = scl & scl_q & sda_q & ~sda;
  assign bus_stop  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_stx_fsm.sv
module i2c_stx_fsm
  import i2c_stx_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic          tx_last,
  output logic          tx_ready,
  output logic          sda_oe,
  output logic [IRQ_N-1:0] evt_set
);
  localparam int SHW  = AW + 1;
  localparam int MAXB = (SHW > DW) ? SHW : DW;
  localparam int CW   = $clog2(MAXB + 1);

  stx_state_e      state;
  logic [SHW-1:0]  ash;
  logic [DW-1:0]   dsh;
  logic [CW-1:0]   cnt;
  logic            last_r, ack_r;
  logic            addr_hit, pop;

  assign addr_hit = (ash[SHW-1:1] == own_addr) && ash[0];

  always_comb begin
    pop = 1'b0;
    if (!bus_start && !bus_stop && scl_fall) begin
      if (state == ST_ADDR && cnt == CW'(SHW) && addr_hit && tx_valid) pop = 1'b1;
      if (state == ST_MACK && ack_r && tx_valid) pop = 1'b1;
    end
  end
  assign tx_ready = pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ash     <= '0;
      dsh     <= '0;
      cnt     <= '0;
      last_r  <= 1'b0;
      ack_r   <= 1'b0;
      sda_oe  <= 1'b0;
      evt_set <= '0;
    end else begin
      evt_set <= '0;
      if (bus_start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && cnt < CW'(SHW)) begin
              ash <= {ash[SHW-2:0], sda};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(SHW)) begin
              if (addr_hit && tx_valid) begin
                dsh    <= tx_data;
                last_r <= tx_last;
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                if (addr_hit) evt_set[IRQ_ERR] <= 1'b1;
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_oe <= ~dsh[DW-1];
              cnt    <= '0;
              state  <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (scl_fall) begin
              if (cnt == CW'(DW-1)) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
                evt_set[IRQ_DONE] <= last_r;
              end else begin
                sda_oe <= ~dsh[DW-2];
                dsh    <= dsh << 1;
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) ack_r <= ~sda;
            else if (scl_fall) begin
              if (!ack_r) begin
                evt_set[IRQ_ABORT] <= 1'b1;
                state <= ST_IDLE;
              end else if (tx_valid) begin
                dsh    <= tx_data;
                last_r <= tx_last;
                sda_oe <= ~tx_data[DW-1];
                cnt    <= '0;
                state  <= ST_DATA;
              end else begin
                evt_set[IRQ_ERR] <= 1'b1;
                state <= ST_FILL;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK) |-> (ash[SHW-1:1] == own_addr && ash[0] && sda_oe)); // R2
  AST_POP_THEN_DRIVE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> (state == ST_AACK || state == ST_DATA)); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R5
  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK) |-> !sda_oe); // R6
  AST_FILL_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |-> !sda_oe); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (state == ST_ADDR && cnt == '0)); // R9
endmodule

// File: rtl/i2c_stx_irq.sv
module i2c_stx_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= (status[i] & ~clr[i]) | set[i];
    end

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !status[i]); // R10
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask);
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status & mask))); // R10
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_stx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  input  logic [IRQ_N-1:0]  irq_mask,
  input  logic [IRQ_N-1:0]  irq_clr,
  output logic [IRQ_N-1:0]  irq_status,
  output logic              irq
);
  logic [1:0]       lines_s;
  logic             scl_rise, scl_fall, bus_start, bus_stop;
  logic [IRQ_N-1:0] evt_set;

  i2c_stx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(lines_s)
  );

  i2c_stx_cond u_cond (
    .clk(clk), .rst(rst), .scl(lines_s[1]), .sda(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_stx_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .sda(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .own_addr(own_addr), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .sda_oe(sda_oe),
    .evt_set(evt_set)
  );

  i2c_stx_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .set(evt_set), .clr(irq_clr),
    .mask(irq_mask), .status(irq_status), .irq(irq)
  );
endmodule

// File: tb/i2c_slave_tx_test.sv
module i2c_slave_tx_test;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, tx_ready, irq;
  logic [6:0] own_addr = 7'h5A;
  logic [2:0] irq_mask = 3'b000, irq_clr = 3'b000, irq_status;
  logic [7:0] mem [16];
  int         idx = 0, nbuf = 0;
  int         checks = 0, errors = 0;
  wire        sda_line = sda_m & ~sda_oe;
  wire        tx_valid = idx < nbuf;
  wire        tx_last  = idx == nbuf - 1;
  wire [7:0]  tx_data  = mem[idx[3:0]];

  always #10 clk = ~clk;

  i2c_slave_tx uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .own_addr(own_addr), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
  );

  always @(posedge clk) if (tx_ready) idx <= idx + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_io(input logic dv, output logic got);
    sda_m = dv; tick(Q); scl_m = 1'b1; tick(Q);
    got = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic g;
    for (int i = 7; i >= 0; i--) bit_io(b[i], g);
    bit_io(1'b1, g);
    acked = ~g;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    logic g;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, g); b[i] = g; end
    bit_io(~give_ack, g);
  endtask

  task automatic clear_all();
    irq_clr = 3'b111; tick(1); irq_clr = 3'b000; tick(2);
  endtask

  function automatic logic [2:0] exp_status(input logic acked, input logic hit,
                                            input int nb, input int nr);
    logic [2:0] s = 3'b000;
    if (hit && nb == 0) s[2] = 1'b1;
    if (acked) begin
      if (nr >= nb) s[0] = 1'b1;
      if (nr > nb)  s[2] = 1'b1;
      else          s[1] = 1'b1;
    end
    return s;
  endfunction

  // full read transaction with expected values from the requirements
  task automatic do_read(input logic [6:0] a, input logic rw, input int nb, input int nr);
    logic acked, hit, exp_ack;
    logic [7:0] got, want;
    int pops;
    clear_all();
    for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
    idx = 0; nbuf = nb;
    hit = (a == own_addr) && rw;
    exp_ack = hit && nb > 0;
    bus_start();
    send_byte({a, rw}, acked);
    chk("R2/R4/R5 address ack", 32'(acked), 32'(exp_ack));
    if (exp_ack) begin
      for (int i = 0; i < nr; i++) begin
        want = (i < nb) ? mem[i] : 8'hFF;
        read_byte(i < nr - 1, got);
        chk((i < nb) ? "R3 data byte" : "R8 underrun ones", 32'(got), 32'(want));
      end
      pops = (nr < nb) ? nr : nb;
    end else begin
      read_byte(1'b0, got);
      chk("R5 released after nack", 32'(got), 32'hFF);
      pops = 0;
    end
    bus_stop();
    tick(4);
    chk("R3/R4/R5 pop count", 32'(idx), 32'(pops));
    chk("R6/R7/R8 status", 32'(irq_status), 32'(exp_status(exp_ack, hit, nb, nr)));
  endtask

  initial begin
    void'($urandom(32'h1C5A));
    tick(5);
    rst = 1'b0;
    tick(1);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    chk("R1 tx_ready", 32'(tx_ready), 0);
    chk("R1 status", 32'(irq_status), 0);
    chk("R1 irq", 32'(irq), 0);

    do_read(7'h5A, 1'b1, 3, 3);   // R3 R6 R7 normal read, master nacks last
    do_read(7'h5B, 1'b1, 2, 1);   // R5 mismatch
    do_read(7'h5A, 1'b0, 2, 1);   // R5 write request
    do_read(7'h5A, 1'b1, 0, 1);   // R4 not ready
    do_read(7'h5A, 1'b1, 1, 3);   // R8 underrun
    do_read(7'h5A, 1'b1, 4, 2);   // R6 early master nack, no done

    // R9 repeated start after three stray address bits
    begin
      logic g, acked;
      logic [7:0] got;
      clear_all();
      for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
      idx = 0; nbuf = 1;
      bus_start();
      bit_io(1'b0, g); bit_io(1'b0, g); bit_io(1'b1, g);
      bus_start();
      send_byte({own_addr, 1'b1}, acked);
      chk("R9 ack after restart", 32'(acked), 1);
      read_byte(1'b0, got);
      chk("R9 data after restart", 32'(got), 32'(mem[0]));
      bus_stop();
      tick(4);
    end

    // R10 mask gating and write-1-to-clear (status now done+abort)
    irq_mask = 3'b100; tick(3);
    chk("R10 masked irq low", 32'(irq), 0);
    irq_mask = 3'b010; tick(3);
    chk("R10 unmasked irq high", 32'(irq), 1);
    irq_clr = 3'b010; tick(1); irq_clr = 3'b000; tick(2);
    chk("R10 clear one bit", 32'(irq_status), 32'b001);
    chk("R10 irq drops", 32'(irq), 0);
    irq_mask = 3'b000;

    for (int it = 0; it < 24; it++) begin
      logic [6:0] a;
      a = ($urandom % 3 == 0) ? 7'($urandom) : own_addr;
      do_read(a, 1'($urandom % 4 != 0), int'($urandom % 5), 1 + int'($urandom % 5));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule